// File: doc/BRIEF.md
# Paged Address Translator with Selectable Map Tables

This block widens a 16-bit processor address to a 20-bit physical address. The upper four processor address bits pick one of 16 entries in a map table. The 8-bit entry becomes physical bits 19:12, and the low twelve bits pass straight through. The result is 1 MB of physical space in 4 KB pages. A map store of 4096 bytes holds 256 such tables. A live-table register chooses which table drives translation.

Software manages the map through three I/O ports, decoded from the low 8 address bits of an I/O cycle:

- **Select port (0x40):** loads the live-table register.
- **Pointer port (0x41):** loads a separate edit-table pointer.
- **Data port (0x42):** reads or writes an entry of the table named by the edit pointer. The entry index comes from bits 15:12 of the I/O address. During a data-port cycle the map store is addressed through the edit pointer. In every other cycle it is addressed through the live-table register.

A built-in fill engine writes identity tables, where entry i holds i. It fills either one named table or all 256 tables, one entry per clock. While it runs, data-port accesses are stalled.

An external bus controller may own the processor bus and issue these I/O cycles itself. For that case, the block gates the controller's own data-bus driver off while a data-port read is in progress, so the two drivers never fight.

Top module: `page_xlat`

## Requirements
- R1: Outside data-port cycles, `phys_addr_o` equals {entry[live_table][cpu_addr_i[15:12]], cpu_addr_i[11:0]}, updating combinationally with the address.
- R2: After reset the live table and the edit pointer are both 0, `busy_o` is 0 and `rdata_oe_o` is 0.
- R3: An I/O write with `cpu_addr_i[7:0]`=0x40 loads the live-table register from `cpu_wdata_i`. An I/O write with `cpu_addr_i[7:0]`=0x41 loads the edit pointer.
- R4: An I/O write with `cpu_addr_i[7:0]`=0x42 stores `cpu_wdata_i` into entry `cpu_addr_i[15:12]` of the edit-pointer table at the clock edge. Translation through a different live table is unchanged.
- R5: An I/O read with `cpu_addr_i[7:0]`=0x42 raises `rdata_oe_o` in the same cycle and puts that entry of the edit-pointer table on `cpu_rdata_o`. In every other cycle `rdata_oe_o` is 0, writes included.
- R6: The map store's write enable and read enable are never active in the same cycle.
- R7: A fill request with `init_all_i`=0 raises `busy_o` after the next clock edge. `busy_o` stays high for exactly 16 cycles, and table `init_tbl_i` then holds identity entries while other tables are untouched.
- R8: A fill request with `init_all_i`=1 keeps `busy_o` high for exactly 4096 cycles, after which every table holds identity entries.
- R9: While `busy_o` is high, data-port writes are dropped and data-port reads do not raise `rdata_oe_o`.
- R10: `ext_drv_en_o` follows `ext_drv_en_i`, except that it is 0 while `ext_grant_i`=1 and a data-port read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | Processor address (memory or I/O cycle) |
| io_wr_i | input | 1 | I/O write cycle strobe |
| io_rd_i | input | 1 | I/O read cycle strobe |
| cpu_wdata_i | input | 8 | Processor data for I/O writes |
| cpu_rdata_o | output | 8 | Map entry returned on data-port reads |
| rdata_oe_o | output | 1 | Enable for the block's data-bus driver |
| phys_addr_o | output | 20 | Translated physical address |
| init_req_i | input | 1 | Start an identity fill (one-cycle pulse) |
| init_all_i | input | 1 | Fill all tables instead of one |
| init_tbl_i | input | 8 | Table to fill when not filling all |
| busy_o | output | 1 | Fill engine running |
| ext_grant_i | input | 1 | External controller owns the bus |
| ext_drv_en_i | input | 1 | External controller requests its data driver |
| ext_drv_en_o | output | 1 | Gated external data-driver enable |

## Verification
Two functions can fall in the same cycle: a fill-engine write and a processor data-port access to the same map store. The bench provokes this by issuing a data-port write, and then a data-port read, while a single-table fill is running on the very table being addressed. It then checks three things. The read must not drive the bus. After the fill ends, the written entry must hold its identity value rather than the processor's data. A neighbouring table must still hold the value written to it before the fill. A second overlap, a data-port read while the controller holds the bus, is judged on the gated driver enable in that same cycle.

// File: rtl/page_xlat_pkg.sv
package page_xlat_pkg;
  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_SEL  = 2'd1,
    HIT_PTR  = 2'd2,
    HIT_DATA = 2'd3
  } port_hit_e;
endpackage

// File: rtl/page_xlat_io.sv
module page_xlat_io
  import page_xlat_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int TBL_W     = 8,
  parameter int DATA_W    = 8,
  parameter logic [PORT_W-1:0] SEL_PORT  = 8'h40,
  parameter logic [PORT_W-1:0] PTR_PORT  = 8'h41,
  parameter logic [PORT_W-1:0] DATA_PORT = 8'h42
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] port_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  output logic [TBL_W-1:0]  live_tbl_o,
  output logic [TBL_W-1:0]  edit_tbl_o,
  output logic              data_cyc_o,
  output logic              data_rd_o,
  output logic              map_we_o,
  output logic              map_oe_o
);
  port_hit_e hit;

  always_comb begin
    if      (port_i == SEL_PORT)  hit = HIT_SEL;
    else if (port_i == PTR_PORT)  hit = HIT_PTR;
    else if (port_i == DATA_PORT) hit = HIT_DATA;
    else                          hit = HIT_NONE;
  end

  logic wr_only, rd_only;
  assign wr_only    = io_wr_i && !io_rd_i;
  assign rd_only    = io_rd_i && !io_wr_i;
  assign data_cyc_o = (hit == HIT_DATA) && (io_wr_i || io_rd_i);
  assign data_rd_o  = (hit == HIT_DATA) && io_rd_i;
  assign map_we_o   = (hit == HIT_DATA) && wr_only && !busy_i;
  assign map_oe_o   = (hit == HIT_DATA) && rd_only && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_tbl_o <= '0;
      edit_tbl_o <= '0;
    end else if (wr_only) begin
      if (hit == HIT_SEL) live_tbl_o <= wdata_i[TBL_W-1:0];
      if (hit == HIT_PTR) edit_tbl_o <= wdata_i[TBL_W-1:0];
    end
  end

  assert_live_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_wr_i && port_i == SEL_PORT) |=> $stable(live_tbl_o));
  assert_edit_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_wr_i && port_i == PTR_PORT) |=> $stable(edit_tbl_o));
  assert_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !map_we_o && !map_oe_o);
endmodule

// File: rtl/page_xlat_init.sv
module page_xlat_init #(
  parameter int TBL_W  = 8,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 8,
  localparam int AW    = TBL_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              all_i,
  input  logic [TBL_W-1:0]  tbl_i,
  output logic              busy_o,
  output logic              we_o,
  output logic [AW-1:0]     addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic [AW-1:0] cur_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cur_q  <= '0;
      last_q <= '0;
    end else if (!busy_o) begin
      if (req_i) begin
        busy_o <= 1'b1;
        cur_q  <= all_i ? '0 : {tbl_i, {IDX_W{1'b0}}};
        last_q <= all_i ? '1 : {tbl_i, {IDX_W{1'b1}}};
      end
    end else begin
      if (cur_q == last_q) busy_o <= 1'b0;
      else                 cur_q  <= cur_q + 1'b1;
    end
  end

  assign we_o   = busy_o;
  assign addr_o = cur_q;
  assign data_o = DATA_W'(cur_q[IDX_W-1:0]);

  assert_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i));
  assert_idx_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> addr_o == $past(addr_o) + 1'b1);
endmodule

// File: rtl/page_xlat_ram.sv
module page_xlat_ram #(
  parameter int AW     = 12,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/page_xlat.sv
module page_xlat #(
  parameter int VA_W   = 16,
  parameter int IDX_W  = 4,
  parameter int ENT_W  = 8,
  parameter int TBL_W  = 8,
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] SEL_PORT  = 8'h40,
  parameter logic [PORT_W-1:0] PTR_PORT  = 8'h41,
  parameter logic [PORT_W-1:0] DATA_PORT = 8'h42,
  localparam int OFF_W = VA_W - IDX_W,
  localparam int PA_W  = ENT_W + OFF_W,
  localparam int RAM_AW = TBL_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VA_W-1:0]   cpu_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [ENT_W-1:0]  cpu_wdata_i,
  output logic [ENT_W-1:0]  cpu_rdata_o,
  output logic              rdata_oe_o,
  output logic [PA_W-1:0]   phys_addr_o,
  input  logic              init_req_i,
  input  logic              init_all_i,
  input  logic [TBL_W-1:0]  init_tbl_i,
  output logic              busy_o,
  input  logic              ext_grant_i,
  input  logic              ext_drv_en_i,
  output logic              ext_drv_en_o
);
  logic [TBL_W-1:0]  live_tbl, edit_tbl, cur_tbl;
  logic              data_cyc, data_rd, map_we, map_oe;
  logic              seq_we;
  logic [RAM_AW-1:0] seq_addr, map_addr, ram_waddr;
  logic [ENT_W-1:0]  seq_data, ram_wdata, ram_rdata;
  logic              ram_we;

  page_xlat_io #(
    .PORT_W(PORT_W), .TBL_W(TBL_W), .DATA_W(ENT_W),
    .SEL_PORT(SEL_PORT), .PTR_PORT(PTR_PORT), .DATA_PORT(DATA_PORT)
  ) u_io (
    .clk_i, .rst_ni,
    .port_i     (cpu_addr_i[PORT_W-1:0]),
    .io_wr_i, .io_rd_i,
    .wdata_i    (cpu_wdata_i),
    .busy_i     (busy_o),
    .live_tbl_o (live_tbl),
    .edit_tbl_o (edit_tbl),
    .data_cyc_o (data_cyc),
    .data_rd_o  (data_rd),
    .map_we_o   (map_we),
    .map_oe_o   (map_oe)
  );

  page_xlat_init #(.TBL_W(TBL_W), .IDX_W(IDX_W), .DATA_W(ENT_W)) u_init (
    .clk_i, .rst_ni,
    .req_i  (init_req_i),
    .all_i  (init_all_i),
    .tbl_i  (init_tbl_i),
    .busy_o (busy_o),
    .we_o   (seq_we),
    .addr_o (seq_addr),
    .data_o (seq_data)
  );

  // edit pointer steers the store only for data-port cycles
  assign cur_tbl   = data_cyc ? edit_tbl : live_tbl;
  assign map_addr  = {cur_tbl, cpu_addr_i[VA_W-1 -: IDX_W]};
  assign ram_we    = seq_we || map_we;
  assign ram_waddr = seq_we ? seq_addr : map_addr;
  assign ram_wdata = seq_we ? seq_data : cpu_wdata_i;

  page_xlat_ram #(.AW(RAM_AW), .DATA_W(ENT_W)) u_ram (
    .clk_i,
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (ram_wdata),
    .raddr_i (map_addr),
    .rdata_o (ram_rdata)
  );

  assign phys_addr_o  = {ram_rdata, cpu_addr_i[OFF_W-1:0]};
  assign cpu_rdata_o  = map_oe ? ram_rdata : '0;
  assign rdata_oe_o   = map_oe;
  assign ext_drv_en_o = ext_drv_en_i && !(ext_grant_i && data_rd);

  assert_we_oe_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_we && rdata_oe_o));
  assert_no_fight_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_grant_i && rdata_oe_o |-> !ext_drv_en_o);
  assert_seq_owns_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_we |-> !map_we);
  assert_oe_on_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_oe_o |-> io_rd_i && !io_wr_i);
endmodule

// File: tb/page_xlat_test.sv
`timescale 1ns/1ps
module page_xlat_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rdata_oe;
  logic [19:0] phys;
  logic        init_req = 1'b0, init_all = 1'b0;
  logic [7:0]  init_tbl = '0;
  logic        busy;
  logic        grant = 1'b0, drv_in = 1'b0, drv_out;

  always #2 clk = ~clk;

  page_xlat uut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(cpu_addr), .io_wr_i(io_wr),
    .io_rd_i(io_rd), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata),
    .rdata_oe_o(rdata_oe), .phys_addr_o(phys), .init_req_i(init_req),
    .init_all_i(init_all), .init_tbl_i(init_tbl), .busy_o(busy),
    .ext_grant_i(grant), .ext_drv_en_i(drv_in), .ext_drv_en_o(drv_out)
  );

  typedef struct {
    string       tag;
    int          kind; // 0 phys 1 rdata 2 oe 3 busy 4 drv 5 given value
    logic [31:0] exp;
    logic [31:0] act;
  } item_t;

  item_t sb[$];
  int total = 0, failed = 0;
  bit done = 0;

  task automatic expect_out(string tag, int kind, logic [31:0] exp, logic [31:0] act = '0);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp; it.act = act;
    sb.push_back(it);
  endtask

  // monitor: compare everything queued for this cycle before the next edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = sb.pop_front();
        case (it.kind)
          0: got = 32'(phys);
          1: got = 32'(rdata);
          2: got = 32'(rdata_oe);
          3: got = 32'(busy);
          4: got = 32'(drv_out);
          default: got = it.act;
        endcase
        total++;
        if (got !== it.exp) begin
          failed++;
          $display("FAIL %s actual=%0h expected=%0h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic io_wr_cyc(logic [7:0] port, logic [3:0] idx, logic [7:0] d);
    cpu_addr = {idx, 4'h0, port}; wdata = d; io_wr = 1'b1;
    expect_out("R5 oe low on write", 2, 0);
    @(negedge clk);
    io_wr = 1'b0; cpu_addr = '0;
  endtask

  task automatic io_rd_chk(string tag, logic [3:0] idx, logic [7:0] exp);
    cpu_addr = {idx, 4'h0, 8'h42}; io_rd = 1'b1;
    expect_out(tag, 2, 1);
    expect_out(tag, 1, 32'(exp));
    @(negedge clk);
    io_rd = 1'b0; cpu_addr = '0;
  endtask

  task automatic xlat_chk(string tag, logic [15:0] va, logic [19:0] exp);
    cpu_addr = va;
    expect_out(tag, 0, 32'(exp));
    @(negedge clk);
  endtask

  task automatic start_fill(logic all, logic [7:0] tbl);
    init_req = 1'b1; init_all = all; init_tbl = tbl;
    @(negedge clk);
    init_req = 1'b0;
    expect_out(all ? "R8 busy rises" : "R7 busy rises", 3, 1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    int n;
    drv_in = 1'b1;
    repeat (2) @(negedge clk);
    // R2 reset state
    expect_out("R2 busy after reset", 3, 0);
    expect_out("R2 oe after reset", 2, 0);
    expect_out("R10 passthrough", 4, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 fill everything
    start_fill(1'b1, 8'h00);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    expect_out("R8 busy length", 5, 4096, 32'(n));
    expect_out("R8 busy falls", 3, 0);
    // R1/R2 live table 0 is identity
    xlat_chk("R1 identity table 0", 16'hA123, 20'h0A123);

    // R3/R4 edit table 5 while table 0 stays live
    io_wr_cyc(8'h41, 4'h0, 8'h05);
    io_wr_cyc(8'h42, 4'h3, 8'hC7);
    xlat_chk("R4 live table undisturbed", 16'h3456, 20'h03456);
    io_rd_chk("R5 readback entry", 4'h3, 8'hC7);
    io_rd_chk("R8 table 5 other entry identity", 4'h9, 8'h09);

    // R3 select table 5 for translation
    io_wr_cyc(8'h40, 4'h0, 8'h05);
    xlat_chk("R1 mapped page", 16'h3456, 20'hC7456);
    xlat_chk("R1 identity page", 16'h7FFF, 20'h07FFF);

    // R10 controller driver gating
    grant = 1'b1;
    cpu_addr = 16'h3042; io_rd = 1'b1;
    expect_out("R10 gated during map read", 4, 0);
    @(negedge clk);
    io_rd = 1'b0; cpu_addr = 16'h3041;
    expect_out("R10 open outside map read", 4, 1);
    @(negedge clk);
    grant = 1'b0;
    cpu_addr = 16'h3042; io_rd = 1'b1;
    expect_out("R10 no grant passthrough", 4, 1);
    @(negedge clk);
    io_rd = 1'b0;

    // table 6 holds a marker across a fill of table 5
    io_wr_cyc(8'h41, 4'h0, 8'h06);
    io_wr_cyc(8'h42, 4'h1, 8'h55);
    io_wr_cyc(8'h41, 4'h0, 8'h05);
    io_wr_cyc(8'h42, 4'h4, 8'h66);

    // R7 single fill with overlapping accesses (R9)
    start_fill(1'b0, 8'h05);
    n = 0;
    while (busy) begin
      if (n == 0) begin
        cpu_addr = 16'h4042; wdata = 8'h99; io_wr = 1'b1;
      end else if (n == 1) begin
        cpu_addr = 16'h4042; io_rd = 1'b1;
        expect_out("R9 read stalled oe", 2, 0);
        expect_out("R6 no drive while filling", 1, 0);
      end
      @(negedge clk);
      io_wr = 1'b0; io_rd = 1'b0; cpu_addr = '0;
      n++;
    end
    expect_out("R7 busy length", 5, 16, 32'(n));
    io_rd_chk("R9 write during fill dropped", 4'h4, 8'h04);
    io_rd_chk("R7 entry restored", 4'h3, 8'h03);
    xlat_chk("R7 live identity after fill", 16'h3456, 20'h03456);
    io_wr_cyc(8'h41, 4'h0, 8'h06);
    io_rd_chk("R7 other table untouched", 4'h1, 8'h55);

    // top table, top entry
    io_wr_cyc(8'h41, 4'h0, 8'hFF);
    io_wr_cyc(8'h42, 4'hF, 8'hFF);
    io_wr_cyc(8'h40, 4'h0, 8'hFF);
    xlat_chk("R1 last table last page", 16'hFFFF, 20'hFFFFF);
    xlat_chk("R1 last table page 0 identity", 16'h0ABC, 20'h00ABC);

    // R2 reset returns live table to 0
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    xlat_chk("R2 live table 0 after reset", 16'hFFFF, 20'h0FFFF);
    io_rd_chk("R2 edit pointer 0 after reset", 4'h2, 8'h02);

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule